// File: doc/BRIEF.md
# Three-Pattern Memory Self-Test Engine

This block is a built-in self-test engine for a word-addressed memory port. A single start pulse gives it a base word address and a region length counted in 32-bit words; the engine then sweeps the region three times. Each sweep first writes every word of the region, then reads every word back and compares it with what was written. The three data patterns are fixed: all zeros, all ones, and finally each word's own index within the region.

The memory side is a request/ready handshake. The engine holds a request, with its address, direction and write data, until the memory accepts it with ready. On a read, the data is taken in the same cycle as ready. The engine stops at the first miscompare. It then reports failure and keeps the failing index, the expected word and the word actually read. A one-cycle done pulse marks the end of every test, and the pass/fail verdict is held until the next accepted start. A full 8 MiB region is 2,097,152 words, which the default length width covers.

Top module: `mbist_engine`

## Requirements
- R1: The first sweep writes 0x00000000 to every word of the region, then reads back and checks every word.
- R2: The second sweep writes 0xFFFFFFFF to every word, then reads back and checks every word.
- R3: The third sweep writes each word's index within the region (zero-extended) as its data, then checks that every word holds its index; after a passing test the memory holds these indices.
- R4: Within a sweep, all writes come first and are followed by all reads. Both run at ascending index 0 to length-1, at address base + index. No read is issued until the sweep's last write has been accepted.
- R5: A request (mem_req, mem_we, mem_addr, mem_wdata) stays unchanged until mem_ready accepts it, and any number of wait cycles is tolerated.
- R6: On the first read whose data differs from the expected word, the engine stops issuing requests, raises fail, and latches fail_index, fail_expected and fail_actual. fail stays high until the next accepted start.
- R7: done is high for exactly one cycle, one cycle after the final accepted read. pass is raised only when all three sweeps complete. pass and fail are never both high, and both are cleared by an accepted start and then held until the next one.
- R8: A start pulse while busy is high is ignored; the running test continues unchanged.
- R9: A region length of zero completes at once: done and pass appear in the cycle after start, and no memory request is made.
- R10: base_addr and region_words are captured on the accepted start; later changes on these inputs have no effect on the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse, accepted only when idle |
| base_addr | input | AW | Word address of index 0 |
| region_words | input | CW | Number of 32-bit words to test |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | All three sweeps completed without miscompare |
| fail | output | 1 | A miscompare stopped the test |
| fail_index | output | CW | Index of the failing word |
| fail_expected | output | DW | Word the engine expected |
| fail_actual | output | DW | Word returned by the memory |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid when a read is accepted |

## Verification
The bench builds the engine with AW = 16, DW = 32 and CW = 9, so lengths up to 511 words are legal. A 256-word behavioural memory is enough to run the largest region used, 255 words, as well as single-word and zero-length regions. The short index keeps full sweeps under all three patterns to a few thousand cycles, even with random stalls on ready. Faults are placed in the memory to show where each sweep catches them. A stuck-low bit is caught by the all-ones sweep. An address alias passes both constant sweeps and is caught only by the index sweep.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } mbist_state_e;

  typedef enum logic [1:0] {
    PH_ZERO  = 2'd0,
    PH_ONES  = 2'd1,
    PH_INDEX = 2'd2
  } mbist_phase_e;

endpackage

// File: rtl/mbist_index_ctr.sv
module mbist_index_ctr #(
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] len,
  output logic [CW-1:0] idx,
  output logic          last
);

  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_d;
  logic [CW-1:0] len_m1;
  logic          idx_en;

  assign len_m1 = len - CW'(1);
  assign last   = (idx_q == len_m1);
  assign idx    = idx_q;
  assign idx_en = clr | step;

  // wrap to zero after the last index so each sweep restarts at index 0
  always_comb begin
    idx_d = idx_q;
    if (clr) begin
      idx_d = '0;
    end else if (step) begin
      idx_d = last ? '0 : idx_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/mbist_pattern.sv
module mbist_pattern
  import mbist_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 22
) (
  input  mbist_phase_e  phase,
  input  logic [CW-1:0] idx,
  output logic [DW-1:0] data
);

  logic [DW-1:0] idx_ext;

  generate
    if (CW >= DW) begin : g_trunc
      assign idx_ext = idx[DW-1:0];
    end else begin : g_zext
      assign idx_ext = {{(DW-CW){1'b0}}, idx};
    end
  endgenerate

  always_comb begin
    unique case (phase)
      PH_ZERO: data = '0;
      PH_ONES: data = '1;
      default: data = idx_ext;
    endcase
  end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_len_zero,
  input  logic         ready,
  input  logic         last,
  input  logic         mismatch,
  output mbist_state_e state,
  output mbist_phase_e phase,
  output logic         cap,
  output logic         idx_clr,
  output logic         idx_step,
  output logic         fin_pass,
  output logic         fin_fail
);

  mbist_state_e state_q, state_d;
  mbist_phase_e phase_q, phase_d;
  logic         ctl_en;

  assign state = state_q;
  assign phase = phase_q;

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    cap      = 1'b0;
    idx_clr  = 1'b0;
    idx_step = 1'b0;
    fin_pass = 1'b0;
    fin_fail = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap     = 1'b1;
          idx_clr = 1'b1;
          phase_d = PH_ZERO;
          if (start_len_zero) begin
            fin_pass = 1'b1;
          end else begin
            state_d = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (ready) begin
          idx_step = 1'b1;
          if (last) begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (ready) begin
          if (mismatch) begin
            fin_fail = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            idx_step = 1'b1;
            if (last) begin
              if (phase_q == PH_INDEX) begin
                fin_pass = 1'b1;
                state_d  = ST_IDLE;
              end else begin
                phase_d = mbist_phase_e'(phase_q + 2'd1);
                state_d = ST_WRITE;
              end
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_d != state_q) || (phase_d != phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ZERO;
    end else if (ctl_en) begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/mbist_result.sv
module mbist_result #(
  parameter int DW = 32,
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          fin_pass,
  input  logic          fin_fail,
  input  logic [CW-1:0] idx,
  input  logic [DW-1:0] expected,
  input  logic [DW-1:0] actual,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [CW-1:0] fail_index,
  output logic [DW-1:0] fail_expected,
  output logic [DW-1:0] fail_actual
);

  logic          done_q, done_d;
  logic          pass_q, pass_d;
  logic          fail_q, fail_d;
  logic          verdict_en;
  logic [CW-1:0] fidx_q;
  logic [DW-1:0] fexp_q;
  logic [DW-1:0] fact_q;

  assign verdict_en = cap | fin_pass | fin_fail;
  assign done_d     = fin_pass | fin_fail;

  // completion wins over the clear so a zero-length start ends in pass
  always_comb begin
    pass_d = pass_q;
    fail_d = fail_q;
    if (cap) begin
      pass_d = 1'b0;
      fail_d = 1'b0;
    end
    if (fin_pass) begin
      pass_d = 1'b1;
    end
    if (fin_fail) begin
      fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (verdict_en) begin
      pass_q <= pass_d;
      fail_q <= fail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fidx_q <= '0;
      fexp_q <= '0;
      fact_q <= '0;
    end else if (fin_fail) begin
      fidx_q <= idx;
      fexp_q <= expected;
      fact_q <= actual;
    end
  end

  assign done          = done_q;
  assign pass          = pass_q;
  assign fail          = fail_q;
  assign fail_index    = fidx_q;
  assign fail_expected = fexp_q;
  assign fail_actual   = fact_q;

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
  import mbist_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] region_words,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [CW-1:0] fail_index,
  output logic [DW-1:0] fail_expected,
  output logic [DW-1:0] fail_actual,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  mbist_state_e  state;
  mbist_phase_e  phase;
  logic          cap;
  logic          idx_clr;
  logic          idx_step;
  logic          fin_pass;
  logic          fin_fail;
  logic          last;
  logic          mismatch;
  logic [CW-1:0] idx;
  logic [DW-1:0] pattern;
  logic [AW-1:0] base_q;
  logic [CW-1:0] len_q;

  // region captured once per accepted start
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else if (cap) begin
      base_q <= base_addr;
      len_q  <= region_words;
    end
  end

  mbist_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .start          (start),
    .start_len_zero (region_words == '0),
    .ready          (mem_ready),
    .last           (last),
    .mismatch       (mismatch),
    .state          (state),
    .phase          (phase),
    .cap            (cap),
    .idx_clr        (idx_clr),
    .idx_step       (idx_step),
    .fin_pass       (fin_pass),
    .fin_fail       (fin_fail)
  );

  mbist_index_ctr #(.CW(CW)) u_idx (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (idx_clr),
    .step  (idx_step),
    .len   (len_q),
    .idx   (idx),
    .last  (last)
  );

  mbist_pattern #(.DW(DW), .CW(CW)) u_pat (
    .phase (phase),
    .idx   (idx),
    .data  (pattern)
  );

  assign mismatch = (mem_rdata != pattern);

  mbist_result #(.DW(DW), .CW(CW)) u_res (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cap           (cap),
    .fin_pass      (fin_pass),
    .fin_fail      (fin_fail),
    .idx           (idx),
    .expected      (pattern),
    .actual        (mem_rdata),
    .done          (done),
    .pass          (pass),
    .fail          (fail),
    .fail_index    (fail_index),
    .fail_expected (fail_expected),
    .fail_actual   (fail_actual)
  );

  assign busy      = (state != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = base_q + AW'(idx);
  assign mem_wdata = pattern;

endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready
);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));

  a_r4_first_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_we);

  a_r4_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $fell(mem_we)) |-> $past(mem_ready));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_ready) |=> busy);

endmodule

bind mbist_engine mbist_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .fail      (fail),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/mbist_engine_tb.sv
`timescale 1ns/1ps
module mbist_engine_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 9;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] base_addr;
  logic [CW-1:0] region_words;
  logic          busy, done, pass, fail;
  logic [CW-1:0] fail_index;
  logic [DW-1:0] fail_expected, fail_actual;
  logic          mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  mbist_engine #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .region_words(region_words), .busy(busy), .done(done), .pass(pass),
    .fail(fail), .fail_index(fail_index), .fail_expected(fail_expected),
    .fail_actual(fail_actual), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- memory model with fault injection ----------------
  logic [31:0] mem [0:255];
  int          stall_mode = 0;
  bit          stuck_en = 0;
  logic [7:0]  stuck_addr;
  logic [31:0] stuck_mask;
  bit          alias_en = 0;
  logic [7:0]  alias_src, alias_dst;

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) begin
      if (stuck_en && mem_addr[7:0] == stuck_addr)
        mem[mem_addr[7:0]] <= mem_wdata & ~stuck_mask;
      else
        mem[mem_addr[7:0]] <= mem_wdata;
      if (alias_en && mem_addr[7:0] == alias_src)
        mem[alias_dst] <= mem_wdata;
    end
  end

  initial mem_ready = 1'b0;
  always @(posedge clk) begin
    #1;
    case (stall_mode)
      0:       mem_ready = 1'b1;
      1:       mem_ready = ($urandom % 3) == 0;
      default: mem_ready = ($urandom % 8) == 0;
    endcase
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // transfer monitor: every accepted request against the expected sequence
  int          op_cnt = 0;
  int          cur_len = 0;
  logic [AW-1:0] cur_base = '0;

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ready && cur_len > 0) begin
      int ph, r, i;
      bit we_exp;
      logic [31:0] d_exp;
      ph = op_cnt / (2 * cur_len);
      r  = op_cnt % (2 * cur_len);
      we_exp = (r < cur_len);
      i  = we_exp ? r : r - cur_len;
      d_exp = (ph == 0) ? 32'h0 : (ph == 1) ? 32'hFFFF_FFFF : 32'(i);
      chk(ph < 3, "R7 no request after third sweep", 32'(ph), 32'd2);
      chk(mem_we == we_exp, "R4 write/read order", 32'(mem_we), 32'(we_exp));
      chk(mem_addr == cur_base + AW'(i), "R4 ascending address",
          32'(mem_addr), 32'(cur_base + AW'(i)));
      if (we_exp) begin
        if (ph == 0) chk(mem_wdata == d_exp, "R1 zero data", mem_wdata, d_exp);
        else if (ph == 1) chk(mem_wdata == d_exp, "R2 ones data", mem_wdata, d_exp);
        else chk(mem_wdata == d_exp, "R3 index data", mem_wdata, d_exp);
      end
      op_cnt++;
    end
  end

  task automatic launch(input logic [AW-1:0] b, input int len);
    @(negedge clk);
    base_addr    = b;
    region_words = CW'(len);
    cur_base     = b;
    cur_len      = len;
    op_cnt       = 0;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; base_addr = '0; region_words = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R7 reset idle", 32'(busy), 32'd0);
    chk(!done && !pass && !fail, "R7 reset verdict", {29'd0, done, pass, fail}, 32'd0);
  endtask

  task automatic t_pass(input logic [AW-1:0] b, input int len, input int mode);
    stall_mode = mode;
    launch(b, len);
    wait_done();
    chk(done, "R7 done seen", 32'(done), 32'd1);
    chk(pass && !fail, "R7 pass verdict", {30'd0, pass, fail}, 32'd2);
    chk(op_cnt == 6 * len, "R1 R2 R3 full sweeps", 32'(op_cnt), 32'(6 * len));
    @(negedge clk);
    chk(!done, "R7 done one cycle", 32'(done), 32'd0);
    repeat (4) @(negedge clk);
    chk(pass, "R7 pass held", 32'(pass), 32'd1);
    for (int i = 0; i < len; i++)
      chk(mem[8'(b + AW'(i))] == 32'(i), "R3 final contents",
          mem[8'(b + AW'(i))], 32'(i));
  endtask

  task automatic t_stuck();
    stall_mode = 1;
    stuck_en = 1; stuck_addr = 8'h15; stuck_mask = 32'h1;
    launch(16'h0010, 16);
    wait_done();
    chk(fail && !pass, "R6 stuck bit fails", {30'd0, pass, fail}, 32'd1);
    chk(fail_index == 9'd5, "R6 fail index", 32'(fail_index), 32'd5);
    chk(fail_expected == 32'hFFFF_FFFF, "R2 fail expected", fail_expected, 32'hFFFF_FFFF);
    chk(fail_actual == 32'hFFFF_FFFE, "R6 fail actual", fail_actual, 32'hFFFF_FFFE);
    chk(op_cnt == 54, "R6 abort at first miscompare", 32'(op_cnt), 32'd54);
    repeat (6) @(negedge clk);
    chk(fail && !mem_req, "R6 fail held, requests stopped", {30'd0, fail, mem_req}, 32'd2);
    stuck_en = 0;
  endtask

  task automatic t_alias();
    stall_mode = 2;
    alias_en = 1; alias_src = 8'h4C; alias_dst = 8'h43;
    launch(16'h0040, 20);
    wait_done();
    chk(fail && !pass, "R3 alias caught by index sweep", {30'd0, pass, fail}, 32'd1);
    chk(fail_index == 9'd3, "R6 alias index", 32'(fail_index), 32'd3);
    chk(fail_expected == 32'd3, "R3 alias expected", fail_expected, 32'd3);
    chk(fail_actual == 32'd12, "R6 alias actual", fail_actual, 32'd12);
    chk(op_cnt == 104, "R1 R2 alias passes constant sweeps", 32'(op_cnt), 32'd104);
    alias_en = 0;
    // next start clears the held failure
    stall_mode = 0;
    launch(16'h0000, 4);
    chk(!fail && !pass, "R7 start clears verdict", {30'd0, pass, fail}, 32'd0);
    wait_done();
    chk(pass, "R7 pass after cleared fail", 32'(pass), 32'd1);
  endtask

  task automatic t_zero();
    stall_mode = 0;
    launch(16'h0030, 0);
    chk(done && pass && !fail, "R9 zero length completes", {29'd0, done, pass, fail}, 32'd6);
    chk(!mem_req && op_cnt == 0, "R9 no request", 32'(op_cnt), 32'd0);
    @(negedge clk);
    chk(!done && !busy, "R9 single done", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_busy_start();
    stall_mode = 1;
    launch(16'h0080, 10);
    repeat (15) @(negedge clk);
    base_addr = 16'h0000; region_words = 9'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8 still busy after start", 32'(busy), 32'd1);
    base_addr = 16'h00F0; region_words = 9'd200;
    wait_done();
    chk(pass && op_cnt == 60, "R8 R10 run unchanged", 32'(op_cnt), 32'd60);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5A5_0000 | 32'(i);
    t_reset();
    t_pass(16'h0020, 16, 0);
    t_pass(16'h0005, 1, 1);
    t_pass(16'h0000, 255, 1);
    t_pass(16'h0060, 37, 2);
    t_stuck();
    t_alias();
    t_zero();
    t_busy_start();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule